// File: doc/BRIEF.md
# Clock Divider with Selective Reset

This block is the synchronous output stage of a clock driver. A fast oscillator clock, or in test mode a reference clock that bypasses the oscillator, drives a three-stage divider. The divider produces a double-rate clock, a bank of base-rate clocks at half that frequency, and a half-rate clock at half the base rate. All rising edges line up. A select pin picks either the base-rate clock or the half-rate clock as the feedback clock returned to the phase comparator. That choice sets a 1x or 2x multiplication of the reference.

An active-low master reset stops only the processor-facing outputs: the double-rate clock and the lowest `NUM_GATED` base-rate outputs. The remaining base-rate outputs, the half-rate clock and the feedback clock keep running. They come from a divider that master reset never touches, so the loop stays locked while the processor is powered down. The release of master reset passes through a synchronizer. The gated outputs then resume only at a base-rate period boundary, so they restart in phase with the free outputs and without a runt pulse. A power-on reset clears every stage. The lock indicator passes through only while the loop is enabled.

Top module: `clkgen_gated_div`

## Requirements
- R1: `dbl_clk_o` toggles on every core clock cycle (core/2). The base-rate outputs run at core/4. Each rising edge of `base_clk_o[0]` coincides with a rising edge of `dbl_clk_o`.
- R2: `half_clk_o` runs at core/8. Each of its rising edges coincides with a rising edge of `base_clk_o[NUM_BASE-1]`.
- R3: `fb_clk_o` equals `base_clk_o[NUM_BASE-1]` when `fb_half_sel` is 0 and `half_clk_o` when it is 1, including while master reset is active.
- R4: A low on `cpu_rst_n` forces `dbl_clk_o` and `base_clk_o[NUM_GATED-1:0]` low. This takes effect no later than `SYNC_STAGES+1` core edges after the change, and the outputs stay low while the reset is held.
- R5: While `cpu_rst_n` is low, `base_clk_o[NUM_BASE-1:NUM_GATED]` and `half_clk_o` keep toggling at their normal rates.
- R6: After `cpu_rst_n` rises, the gated outputs equal the free-running base-rate output (and `dbl_clk_o` toggles each cycle) within `SYNC_STAGES+6` core cycles, well inside 3 base-rate periods. Their first rising edge coincides with a rising edge of the free outputs, and no shortened high pulse appears.
- R7: `lock_o` equals `loop_locked_in` when `loop_en` is 1 and is 0 when `loop_en` is 0.
- R8: When `loop_en` is 0, `ref_clk` replaces `osc_clk` as the core clock, so the base-rate outputs run at ref/4. `loop_en` is changed only while `por_n` is low.
- R9: `por_n` low drives every clock output low at once, without waiting for a clock edge. On the first core edge after release, `base_clk_o[NUM_BASE-1]` and `half_clk_o` rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock (core clock in normal mode) |
| ref_clk | input | 1 | Reference clock, core clock when the loop is disabled |
| loop_en | input | 1 | 1: oscillator drives the divider; 0: static test bypass |
| por_n | input | 1 | Asynchronous active-low power-on reset of all stages |
| cpu_rst_n | input | 1 | Active-low master reset of the processor-facing outputs |
| fb_half_sel | input | 1 | 0: base-rate feedback; 1: half-rate feedback |
| loop_locked_in | input | 1 | Lock status from the analog loop |
| dbl_clk_o | output | 1 | Double-rate clock (gated by master reset) |
| base_clk_o | output | NUM_BASE | Base-rate clocks; bits below NUM_GATED are gated |
| half_clk_o | output | 1 | Half-rate clock, free running |
| fb_clk_o | output | 1 | Feedback clock to the phase comparator |
| lock_o | output | 1 | Lock indicator, low whenever the loop is disabled |

## Verification
Two events can land on the same core edge. The first is the end of the master-reset synchronizer delay. The second is a rising edge of the free-running outputs at the base-rate period boundary. A gate that opened one edge too late or too early would produce a runt or a phase-shifted pulse. The bench applies master-reset pulses of random length from a fixed seed, so the release crosses every divider phase. It then requires the first gated rising edge to coincide with a free base-rate and double-rate rising edge, and requires the gated outputs to track the free ones exactly afterwards. Feedback selection is also exercised while the reset is asserted, to show that it is unaffected.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
  // divider state width: double, base and half rate stages
  localparam int unsigned PHASE_W = 3;
  typedef logic [PHASE_W-1:0] phase_t;

  // stage bit positions inside the down counter
  localparam int unsigned DBL_BIT  = 0;
  localparam int unsigned BASE_BIT = 1;
  localparam int unsigned HALF_BIT = 2;

  // low two counter bits on the edge before a base-rate period boundary
  localparam logic [1:0] REL_PHASE = 2'b01;
endpackage

// File: rtl/cgd_clk_sel.sv
module cgd_clk_sel (
  input  logic use_osc,
  input  logic osc_clk,
  input  logic ref_clk,
  output logic core_clk
);
  // select only changes while the divider is held in power-on reset
  assign core_clk = use_osc ? osc_clk : ref_clk;
endmodule

// File: rtl/cgd_rst_sync.sv
module cgd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], async_n};
  end

  assign sync_n = shreg[STAGES-1];
endmodule

// File: rtl/cgd_phase_div.sv
module cgd_phase_div
  import cgd_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  output phase_t cnt_q,
  output phase_t cnt_nx
);
  // down counter: every bit rises on the same edge (wrap 0 -> all ones)
  assign cnt_nx = phase_t'(cnt_q - 1'b1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/cgd_gate_ctl.sv
module cgd_gate_ctl
  import cgd_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hold_n,
  input  logic [1:0] phase_lo,
  output logic       run_en
);
  logic run_q;

  // open only when the next state starts a base-rate period
  assign run_en = hold_n & (run_q | (phase_lo == REL_PHASE));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end
endmodule

// File: rtl/cgd_out_bank.sv
module cgd_out_bank #(
  parameter int unsigned NUM_BASE  = 4,
  parameter int unsigned NUM_GATED = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                run_en,
  input  logic                nx_dbl,
  input  logic                nx_base,
  input  logic                free_base,
  input  logic                free_half,
  input  logic                fb_half_sel,
  output logic                dbl_o,
  output logic [NUM_BASE-1:0] base_o,
  output logic                half_o,
  output logic                fb_o
);
  logic dbl_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) dbl_q <= 1'b0;
    else        dbl_q <= run_en & nx_dbl;
  end
  assign dbl_o = dbl_q;

  for (genvar i = 0; i < NUM_BASE; i++) begin : g_base
    if (i < NUM_GATED) begin : g_gated
      logic q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= 1'b0;
        else        q <= run_en & nx_base;
      end
      assign base_o[i] = q;
    end else begin : g_free
      assign base_o[i] = free_base;
    end
  end

  assign half_o = free_half;
  assign fb_o   = fb_half_sel ? free_half : free_base;
endmodule

// File: rtl/clkgen_gated_div.sv
module clkgen_gated_div
  import cgd_pkg::*;
#(
  parameter int unsigned NUM_BASE    = 4,
  parameter int unsigned NUM_GATED   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                osc_clk,
  input  logic                ref_clk,
  input  logic                loop_en,
  input  logic                por_n,
  input  logic                cpu_rst_n,
  input  logic                fb_half_sel,
  input  logic                loop_locked_in,
  output logic                dbl_clk_o,
  output logic [NUM_BASE-1:0] base_clk_o,
  output logic                half_clk_o,
  output logic                fb_clk_o,
  output logic                lock_o
);
  logic   core_clk;
  logic   hold_n;
  logic   run_en;
  phase_t cnt_q;
  phase_t cnt_nx;

  cgd_clk_sel u_clk_sel (
    .use_osc  (loop_en),
    .osc_clk  (osc_clk),
    .ref_clk  (ref_clk),
    .core_clk (core_clk)
  );

  cgd_rst_sync #(.STAGES(SYNC_STAGES)) u_mr_sync (
    .clk     (core_clk),
    .por_n   (por_n),
    .async_n (cpu_rst_n),
    .sync_n  (hold_n)
  );

  // divider untouched by master reset: keeps feedback alive
  cgd_phase_div u_div (
    .clk    (core_clk),
    .por_n  (por_n),
    .cnt_q  (cnt_q),
    .cnt_nx (cnt_nx)
  );

  cgd_gate_ctl u_gate (
    .clk      (core_clk),
    .por_n    (por_n),
    .hold_n   (hold_n),
    .phase_lo (cnt_q[BASE_BIT:DBL_BIT]),
    .run_en   (run_en)
  );

  cgd_out_bank #(.NUM_BASE(NUM_BASE), .NUM_GATED(NUM_GATED)) u_out (
    .clk         (core_clk),
    .por_n       (por_n),
    .run_en      (run_en),
    .nx_dbl      (cnt_nx[DBL_BIT]),
    .nx_base     (cnt_nx[BASE_BIT]),
    .free_base   (cnt_q[BASE_BIT]),
    .free_half   (cnt_q[HALF_BIT]),
    .fb_half_sel (fb_half_sel),
    .dbl_o       (dbl_clk_o),
    .base_o      (base_clk_o),
    .half_o      (half_clk_o),
    .fb_o        (fb_clk_o)
  );

  assign lock_o = loop_en & loop_locked_in;
endmodule

// File: rtl/clkgen_gated_div_chk.sv
module clkgen_gated_div_chk #(
  parameter int unsigned NUM_BASE    = 4,
  parameter int unsigned NUM_GATED   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                core_clk,
  input logic                por_n,
  input logic                cpu_rst_n,
  input logic                loop_en,
  input logic                dbl_clk_o,
  input logic [NUM_BASE-1:0] base_clk_o,
  input logic                half_clk_o,
  input logic                lock_o
);
  localparam logic [4:0] LO_LIM = 5'(SYNC_STAGES + 1);
  localparam logic [4:0] HI_LIM = 5'(SYNC_STAGES + 6);

  logic [4:0] lo_cnt, hi_cnt;
  logic [1:0] up_cnt;

  always_ff @(posedge core_clk or negedge por_n) begin
    if (!por_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      up_cnt <= '0;
    end else begin
      lo_cnt <= cpu_rst_n ? 5'd0 : ((lo_cnt == 5'd31) ? lo_cnt : lo_cnt + 5'd1);
      hi_cnt <= !cpu_rst_n ? 5'd0 : ((hi_cnt == 5'd31) ? hi_cnt : hi_cnt + 5'd1);
      up_cnt <= (up_cnt == 2'd3) ? up_cnt : up_cnt + 2'd1;
    end
  end

  a_r1_dbl_aligned: assert property (@(posedge core_clk) disable iff (!por_n)
    $rose(base_clk_o[0]) |-> $rose(dbl_clk_o));

  a_r2_half_aligned: assert property (@(posedge core_clk) disable iff (!por_n)
    $rose(half_clk_o) |-> $rose(base_clk_o[NUM_BASE-1]));

  a_r4_gated_low: assert property (@(posedge core_clk) disable iff (!por_n)
    (lo_cnt >= LO_LIM) |-> (!dbl_clk_o && base_clk_o[NUM_GATED-1:0] == '0));

  a_r5_free_toggles: assert property (@(posedge core_clk) disable iff (!por_n)
    (up_cnt >= 2'd2) |-> (base_clk_o[NUM_BASE-1] != $past(base_clk_o[NUM_BASE-1], 2)));

  a_r6_rejoined: assert property (@(posedge core_clk) disable iff (!por_n)
    (hi_cnt >= HI_LIM) |->
      (base_clk_o[NUM_GATED-1:0] == {NUM_GATED{base_clk_o[NUM_BASE-1]}}));

  a_r7_lock_off: assert property (@(posedge core_clk) disable iff (!por_n)
    !loop_en |-> !lock_o);
endmodule

bind clkgen_gated_div clkgen_gated_div_chk #(
  .NUM_BASE(NUM_BASE), .NUM_GATED(NUM_GATED), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .core_clk   (core_clk),
  .por_n      (por_n),
  .cpu_rst_n  (cpu_rst_n),
  .loop_en    (loop_en),
  .dbl_clk_o  (dbl_clk_o),
  .base_clk_o (base_clk_o),
  .half_clk_o (half_clk_o),
  .lock_o     (lock_o)
);

// File: tb/sim_clkgen_gated_div.sv
module sim_clkgen_gated_div;
  localparam int NB = 4;
  localparam int NG = 2;
  localparam int SS = 2;

  logic osc_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic loop_en = 1'b1;
  logic por_n = 1'b1;
  logic cpu_rst_n = 1'b1;
  logic fb_half_sel = 1'b0;
  logic loop_locked_in = 1'b0;
  logic dbl, half, fb, lock;
  logic [NB-1:0] base;

  always #5 osc_clk = ~osc_clk;
  always #17 ref_clk = ~ref_clk;

  clkgen_gated_div #(.NUM_BASE(NB), .NUM_GATED(NG), .SYNC_STAGES(SS)) u0 (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .loop_en(loop_en), .por_n(por_n),
    .cpu_rst_n(cpu_rst_n), .fb_half_sel(fb_half_sel), .loop_locked_in(loop_locked_in),
    .dbl_clk_o(dbl), .base_clk_o(base), .half_clk_o(half), .fb_clk_o(fb), .lock_o(lock)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic p_dbl, p_half;
  logic [NB-1:0] p_base;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    p_dbl = dbl; p_base = base; p_half = half;
    if (loop_en) @(negedge osc_clk);
    else         @(negedge ref_clk);
  endtask

  function automatic bit all_low();
    return !dbl && base == '0 && !half && !fb;
  endfunction

  function automatic int fb_exp();
    return fb_half_sel ? int'(half) : int'(base[NB-1]);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #2 por_n = 1'b0;
    repeat (3) step();
    chk(all_low(), "R9 reset state", int'({dbl, base, half, fb}), 0);

    // first edge after release: free base and half rise together
    por_n = 1'b1;
    step();
    chk(base[NB-1] && half && !p_base[NB-1] && !p_half, "R9 first edge", int'({base[NB-1], half}), 3);
    repeat (16) step();

    // R1 / R2: rates and edge alignment over a whole number of periods
    begin
      int rd = 0, rb0 = 0, rb3 = 0, rh = 0, mis = 0;
      for (int k = 0; k < 64; k++) begin
        step();
        if (!p_dbl && dbl) rd++;
        if (!p_base[0] && base[0]) begin rb0++; if (!(!p_dbl && dbl)) mis++; end
        if (!p_base[NB-1] && base[NB-1]) rb3++;
        if (!p_half && half) begin rh++; if (!(!p_base[NB-1] && base[NB-1])) mis++; end
      end
      chk(rd == 32, "R1 double-rate edges", rd, 32);
      chk(rb0 == 16, "R1 gated base edges", rb0, 16);
      chk(rb3 == 16, "R1 free base edges", rb3, 16);
      chk(rh == 8, "R2 half-rate edges", rh, 8);
      chk(mis == 0, "R1 R2 edge alignment", mis, 0);
    end

    // R3 / R7: random feedback select and lock input
    for (int k = 0; k < 40; k++) begin
      fb_half_sel = 1'($urandom_range(0, 1));
      loop_locked_in = 1'($urandom_range(0, 1));
      #1;
      chk(int'(fb) == fb_exp(), "R3 feedback select", int'(fb), fb_exp());
      chk(lock == loop_locked_in, "R7 lock pass", int'(lock), int'(loop_locked_in));
      repeat ($urandom_range(1, 5)) step();
      chk(int'(fb) == fb_exp(), "R3 feedback after edge", int'(fb), fb_exp());
    end

    // R4 / R5 / R6: master reset pulses of random length
    for (int it = 0; it < 8; it++) begin
      int len, bad, r3, rh, fbbad, first, mism;
      bit aligned;
      len = $urandom_range(8, 41);
      bad = 0; r3 = 0; rh = 0; fbbad = 0;
      cpu_rst_n = 1'b0;
      repeat (SS + 1) step();
      for (int k = 0; k < len; k++) begin
        step();
        if (dbl || base[NG-1:0] != '0) bad++;
        if (!p_base[NB-1] && base[NB-1]) r3++;
        if (!p_half && half) rh++;
        fb_half_sel = 1'($urandom_range(0, 1));
        #1;
        if (int'(fb) != fb_exp()) fbbad++;
      end
      chk(bad == 0, "R4 gated outputs held low", bad, 0);
      chk(r3 >= len / 4 && r3 <= (len + 3) / 4, "R5 free base toggles", r3, len / 4);
      chk(rh >= len / 8 && rh <= (len + 7) / 8, "R5 half toggles", rh, len / 8);
      chk(fbbad == 0, "R3 feedback during reset", fbbad, 0);

      cpu_rst_n = 1'b1;
      first = -1; aligned = 1'b0;
      for (int k = 0; k < 12; k++) begin
        step();
        if (first < 0 && !p_base[0] && base[0]) begin
          first = k;
          aligned = (!p_base[NB-1] && base[NB-1]) && (!p_dbl && dbl);
        end
      end
      chk(first >= 0, "R6 restart within limit", first, 0);
      chk(aligned, "R6 restart in phase", int'(aligned), 1);
      mism = 0;
      for (int k = 0; k < 16; k++) begin
        step();
        if (base[NG-1:0] != {NG{base[NB-1]}} || dbl == p_dbl) mism++;
      end
      chk(mism == 0, "R6 gated tracks free", mism, 0);
    end

    // R8 / R7: test bypass, reference clock drives the chain
    por_n = 1'b0;
    #1 loop_en = 1'b0;
    loop_locked_in = 1'b1;
    #1;
    chk(lock == 1'b0, "R7 lock forced low", int'(lock), 0);
    repeat (3) step();
    por_n = 1'b1;
    begin
      int rb = 0;
      for (int k = 0; k < 64; k++) begin
        step();
        if (!p_base[NB-1] && base[NB-1]) rb++;
      end
      chk(rb == 16, "R8 bypass rate", rb, 16);
    end
    chk(lock == 1'b0, "R7 lock low in bypass", int'(lock), 0);

    // R9: power-on reset in the middle of operation clears outputs at once
    por_n = 1'b0;
    #1;
    chk(all_low(), "R9 async clear", int'({dbl, base, half, fb}), 0);
    loop_en = 1'b1;
    repeat (3) step();
    por_n = 1'b1;
    repeat (20) step();
    chk(dbl != p_dbl, "R1 running after restart", int'(dbl), int'(!p_dbl));

    done = 1;
    summary();
  end
endmodule